// File: doc/BRIEF.md
# Four-Channel Counter-Timer with Vectored Interrupts

The block holds four independent 8-bit down-counting channels and a small interrupt unit. A CPU sets each channel up by writing bytes to it: a control byte picks the mode, the prescale ratio and whether the channel may interrupt, and can announce that the next byte is the time constant. In timer mode a channel counts system clock-enable cycles through a divide-by-16 or divide-by-256 prescaler. In counter mode it counts enable cycles in which its trigger input is high. No real clock edges are used, so there is no edge polarity choice. When a channel's count runs out it reloads the time constant and raises its zero-count output for one enable period.

A typical use gives one channel a once-per-frame trigger from the video line counter. Two channels act as one-shot timers that their service routines stop. The fourth is a free-running timer for periodic polling. Channel 0's zero-count output is also fed into channel 1's trigger, so the two can form a longer chain.

The interrupt unit sits apart from the channels. There is no daisy chain. Any pending channel raises the request, and the lowest-numbered pending channel wins. The vector it returns is a programmed base with the channel number in bits 2:1. An acknowledge clears the pending flag of that channel only.

Top module: `quadCounterTimer`

## Requirements
- R1: After reset, all zero-count outputs are 0, intReq is 0 and intVector is 0xD0.
- R2: A byte with bit 0 set is a control byte for the addressed channel. Its bits have these meanings: bit 7 enables interrupts, bit 6 selects counter mode (0 selects timer mode), bit 5 selects the divide-by-256 prescaler (0 selects divide-by-16), bit 2 means a time constant follows and bit 1 stops the channel. When bit 2 is set, the next byte written to that channel is taken as its time constant whatever its value. Writing it loads the counter, clears the prescaler and starts the channel.
- R3: In timer mode a running channel decrements once every 16 or 256 enable cycles. The first decrement comes after a full prescale period counted from the time-constant write. When a decrement finds the count at 1, the channel reloads the time constant, so the period is TC prescaled ticks, and a TC of 0 gives 256 ticks.
- R4: In counter mode a running channel decrements on each enable cycle in which its trigger input is high. It reloads as in R3.
- R5: A terminal count raises zeroCount[n] on the following cycle. The output stays high until the next enable cycle, where it clears unless another terminal count occurs.
- R6: Channel 1's trigger is the OR of trig[1] and channel 0's zero-count output.
- R7: A control byte with bit 1 set stops the channel, so it gives no further decrements and no zero-count pulses, and it clears that channel's pending interrupt.
- R8: A terminal count on a channel with interrupts enabled sets its pending flag. intReq is high whenever any flag is pending. With interrupts disabled, the channel still pulses zeroCount but sets no flag.
- R9: intVector reports the lowest-numbered pending channel. A pulse on intAck while a request is pending clears only that channel's flag.
- R10: intVector equals the base with bits 2:1 holding the channel number and bit 0 at 0. The reset base gives vectors 0xD0, 0xD2, 0xD4 and 0xD6 for channels 0 to 3. With nothing pending, bits 2:1 are 0.
- R11: A byte with bit 0 clear, written to channel 0 when no time constant is expected, sets base bits 7:3. Such a byte written to any other channel has no effect.
- R12: In a cycle with clkEn low, no prescaler or counter advances and the zero-count outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Count enable; all counting steps on cycles where it is high |
| wrEn | input | 1 | Write strobe for one byte |
| wrChan | input | 2 | Channel addressed by the write |
| wrData | input | 8 | Control, time-constant or base byte |
| trig | input | 4 | Per-channel trigger levels for counter mode |
| intAck | input | 1 | Interrupt acknowledge pulse |
| zeroCount | output | 4 | Per-channel terminal-count pulses |
| intReq | output | 1 | Interrupt request, high while any channel is pending |
| intVector | output | 8 | Vector of the lowest pending channel |

## Verification
The timer paths run first with a steady enable and then with an enable gated to one cycle in three, which separates prescaler stepping from raw clock counting. Counter mode is driven with random trigger levels and then with a constant trigger and a zero time constant, to reach the 256-count wrap. The chain from channel 0 to channel 1 is run with trig[1] held low, so any channel 1 pulse can only come from the link. Two channels are made pending together and then acknowledged one at a time, which tests the priority order and the vector offsets. A final stretch with random enables, triggers, acknowledges and control writes checks that every write precedence matches the reference model cycle by cycle.

// File: rtl/qctPkg.sv
`timescale 1ns/1ps
package qctPkg;
  localparam int CH_COUNT = 4;
  localparam int DATA_W   = 8;
  localparam int CH_W     = $clog2(CH_COUNT);

  // control byte fields
  localparam int BIT_CTRL   = 0;
  localparam int BIT_STOP   = 1;
  localparam int BIT_TCNEXT = 2;
  localparam int BIT_SLOW   = 5;
  localparam int BIT_COUNT  = 6;
  localparam int BIT_IE     = 7;

  // control -> datapath strobes and mode levels
  typedef struct packed {
    logic [CH_COUNT-1:0] load;
    logic [CH_COUNT-1:0] run;
    logic [CH_COUNT-1:0] counterMode;
    logic [CH_COUNT-1:0] slowPre;
    logic [DATA_W-1:0]   tcValue;
  } ctlStrobes_t;
endpackage

// File: rtl/qctControl.sv
`timescale 1ns/1ps
module qctControl
  import qctPkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_RESET = 8'hD0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CH_W-1:0]     wrChan,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                intAck,
  input  logic [CH_COUNT-1:0] eventVec,
  output ctlStrobes_t         strb,
  output logic                intReq,
  output logic [DATA_W-1:0]   intVector,
  output logic [CH_COUNT-1:0] pendVec
);
  localparam int BASE_LO = CH_W + 1;

  logic [CH_COUNT-1:0] runQ, countQ, slowQ, ieQ, expTcQ, pendQ;
  logic [DATA_W-1:BASE_LO] baseQ;

  logic [CH_COUNT-1:0] wrSel, loadSel, ctlSel, stopSel, ackMask;
  logic                baseWr, anyPend;
  logic [CH_W-1:0]     lowIdx;

  always_comb begin
    wrSel = '0;
    if (wrEn) wrSel[wrChan] = 1'b1;
  end

  assign loadSel = wrSel & expTcQ;
  assign ctlSel  = wrData[BIT_CTRL] ? (wrSel & ~expTcQ) : '0;
  assign stopSel = wrData[BIT_STOP] ? ctlSel : '0;
  assign baseWr  = wrSel[0] & ~expTcQ[0] & ~wrData[BIT_CTRL];

  // fixed priority: lowest channel number wins
  always_comb begin
    lowIdx = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (pendQ[i]) lowIdx = CH_W'(i);
    end
  end

  assign anyPend = |pendQ;

  always_comb begin
    ackMask = '0;
    if (intAck && anyPend) ackMask[lowIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= '0;
      countQ <= '0;
      slowQ  <= '0;
      ieQ    <= '0;
      expTcQ <= '0;
      pendQ  <= '0;
      baseQ  <= VEC_RESET[DATA_W-1:BASE_LO];
    end else begin
      for (int i = 0; i < CH_COUNT; i++) begin
        if (loadSel[i]) begin
          runQ[i]   <= 1'b1;
          expTcQ[i] <= 1'b0;
        end else if (ctlSel[i]) begin
          ieQ[i]    <= wrData[BIT_IE];
          countQ[i] <= wrData[BIT_COUNT];
          slowQ[i]  <= wrData[BIT_SLOW];
          expTcQ[i] <= wrData[BIT_TCNEXT];
          if (wrData[BIT_STOP]) runQ[i] <= 1'b0;
        end
      end
      pendQ <= ((pendQ & ~ackMask) | (eventVec & ieQ)) & ~stopSel;
      if (baseWr) baseQ <= wrData[DATA_W-1:BASE_LO];
    end
  end

  assign strb.load        = loadSel;
  assign strb.run         = runQ;
  assign strb.counterMode = countQ;
  assign strb.slowPre     = slowQ;
  assign strb.tcValue     = wrData;

  assign intReq    = anyPend;
  assign intVector = {baseQ, lowIdx, 1'b0};
  assign pendVec   = pendQ;
endmodule

// File: rtl/qctDatapath.sv
`timescale 1ns/1ps
module qctDatapath
  import qctPkg::*;
#(
  parameter int PRE_FAST = 16,
  parameter int PRE_SLOW = 256,
  parameter bit CHAIN01  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic [CH_COUNT-1:0] trig,
  input  ctlStrobes_t         strb,
  output logic [CH_COUNT-1:0] zeroCount,
  output logic [CH_COUNT-1:0] eventVec
);
  localparam int PRE_W = $clog2(PRE_SLOW);
  localparam logic [PRE_W-1:0] FAST_MAX = PRE_W'(PRE_FAST - 1);
  localparam logic [PRE_W-1:0] SLOW_MAX = PRE_W'(PRE_SLOW - 1);

  logic [CH_COUNT-1:0] trigSel;

  for (genvar c = 0; c < CH_COUNT; c++) begin : gCh
    if (CHAIN01 && c == 1) begin : gChain
      assign trigSel[c] = trig[c] | zeroCount[0];
    end else begin : gPlain
      assign trigSel[c] = trig[c];
    end

    logic [DATA_W-1:0] cntQ, tcQ;
    logic [PRE_W-1:0]  preQ;
    logic              preEnd, tickEn, stepEn, zcQ;

    assign preEnd = preQ == (strb.slowPre[c] ? SLOW_MAX : FAST_MAX);
    assign tickEn = clkEn & strb.run[c] & ~strb.counterMode[c];
    assign stepEn = strb.run[c] &
                    (strb.counterMode[c] ? (clkEn & trigSel[c]) : (tickEn & preEnd));
    assign eventVec[c] = stepEn & (cntQ == DATA_W'(1)) & ~strb.load[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
        tcQ  <= '0;
        preQ <= '0;
        zcQ  <= 1'b0;
      end else begin
        if (strb.load[c]) begin
          tcQ  <= strb.tcValue;
          cntQ <= strb.tcValue;
          preQ <= '0;
        end else begin
          if (tickEn) preQ <= preEnd ? '0 : preQ + 1'b1;
          if (stepEn) cntQ <= (cntQ == DATA_W'(1)) ? tcQ : cntQ - 1'b1;
        end
        if (clkEn) zcQ <= eventVec[c];
      end
    end

    assign zeroCount[c] = zcQ;
  end
endmodule

// File: rtl/quadCounterTimer.sv
`timescale 1ns/1ps
module quadCounterTimer
  import qctPkg::*;
#(
  parameter int                PRE_FAST  = 16,
  parameter int                PRE_SLOW  = 256,
  parameter bit                CHAIN01   = 1'b1,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'hD0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic                wrEn,
  input  logic [CH_W-1:0]     wrChan,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CH_COUNT-1:0] trig,
  input  logic                intAck,
  output logic [CH_COUNT-1:0] zeroCount,
  output logic                intReq,
  output logic [DATA_W-1:0]   intVector
);
  ctlStrobes_t         ctlStrb;
  logic [CH_COUNT-1:0] eventVec;
  logic [CH_COUNT-1:0] pendVec;

  qctControl #(.VEC_RESET(VEC_RESET)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrChan    (wrChan),
    .wrData    (wrData),
    .intAck    (intAck),
    .eventVec  (eventVec),
    .strb      (ctlStrb),
    .intReq    (intReq),
    .intVector (intVector),
    .pendVec   (pendVec)
  );

  qctDatapath #(
    .PRE_FAST (PRE_FAST),
    .PRE_SLOW (PRE_SLOW),
    .CHAIN01  (CHAIN01)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .trig      (trig),
    .strb      (ctlStrb),
    .zeroCount (zeroCount),
    .eventVec  (eventVec)
  );
endmodule

// File: rtl/qctChecker.sv
`timescale 1ns/1ps
module qctChecker
  import qctPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                clkEn,
  input logic                intAck,
  input logic [CH_COUNT-1:0] zeroCount,
  input logic                intReq,
  input logic [CH_W-1:0]     vecIdx,
  input logic [CH_COUNT-1:0] pendVec,
  input logic [CH_COUNT-1:0] runVec,
  input logic [CH_COUNT-1:0] eventVec
);
  logic [CH_COUNT-1:0] lowerMask;

  always_comb begin
    for (int i = 0; i < CH_COUNT; i++) lowerMask[i] = (i < int'(vecIdx));
  end

  // R12: zero-count outputs move only after an enable cycle
  a_r12_zc_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clkEn) |-> $stable(zeroCount));

  // R7: a channel that was not running gives no pulse
  a_r7_stopped_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $past(clkEn) |-> ((zeroCount & ~$past(runVec)) == '0));

  // R9: the vector names a pending channel with none below it
  a_r9_vector_is_lowest: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (pendVec[vecIdx] && ((pendVec & lowerMask) == '0)));

  // R9: acknowledging the only pending channel drops the request
  a_r9_ack_clears_single: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && ($countones(pendVec) == 1) && (eventVec == '0)) |=> !intReq);
endmodule

bind quadCounterTimer qctChecker i_qctChecker (
  .clk       (clk),
  .rstN      (rstN),
  .clkEn     (clkEn),
  .intAck    (intAck),
  .zeroCount (zeroCount),
  .intReq    (intReq),
  .vecIdx    (intVector[qctPkg::CH_W:1]),
  .pendVec   (pendVec),
  .runVec    (ctlStrb.run),
  .eventVec  (eventVec)
);

// File: tb/test_quadCounterTimer.sv
`timescale 1ns/1ps
module test_quadCounterTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrChan = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [3:0] trig = 4'd0;
  logic       intAck = 1'b0;
  logic [3:0] zeroCount;
  logic       intReq;
  logic [7:0] intVector;

  always #2 clk = ~clk;

  quadCounterTimer i_quadCounterTimer (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrChan(wrChan),
    .wrData(wrData), .trig(trig), .intAck(intAck), .zeroCount(zeroCount),
    .intReq(intReq), .intVector(intVector)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // behavioural reference state
  int mCnt[4], mPre[4], mTc[4], pmax[4];
  bit mRun[4], mCm[4], mSlow[4], mIe[4], mExp[4], mPend[4], mZc[4];
  bit ev[4], stp[4], ld[4];
  int mBase;
  int low, wc;

  function automatic int lowestPend();
    for (int i = 0; i < 4; i++) if (mPend[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        mCnt[i] = 0; mPre[i] = 0; mTc[i] = 0; mRun[i] = 0; mCm[i] = 0;
        mSlow[i] = 0; mIe[i] = 0; mExp[i] = 0; mPend[i] = 0; mZc[i] = 0;
      end
      mBase = 'hD0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit tIn;
        tIn = trig[i] | (i == 1 && mZc[0]);
        pmax[i] = mSlow[i] ? 255 : 15;
        ld[i] = wrEn && (int'(wrChan) == i) && mExp[i];
        stp[i] = mRun[i] && (mCm[i] ? (clkEn && tIn) : (clkEn && mPre[i] == pmax[i]));
        ev[i] = stp[i] && mCnt[i] == 1 && !ld[i];
      end
      low = lowestPend();
      for (int i = 0; i < 4; i++) begin
        if (ld[i]) begin
          mTc[i] = int'(wrData); mCnt[i] = int'(wrData); mPre[i] = 0;
        end else begin
          if (clkEn && mRun[i] && !mCm[i]) mPre[i] = (mPre[i] == pmax[i]) ? 0 : mPre[i] + 1;
          if (stp[i]) mCnt[i] = (mCnt[i] == 1) ? mTc[i] : (mCnt[i] + 255) % 256;
        end
        if (clkEn) mZc[i] = ev[i];
      end
      if (intAck && low >= 0) mPend[low] = 0;
      for (int i = 0; i < 4; i++) if (ev[i] && mIe[i]) mPend[i] = 1;
      if (wrEn) begin
        wc = int'(wrChan);
        if (mExp[wc]) begin
          mRun[wc] = 1; mExp[wc] = 0;
        end else if (wrData[0]) begin
          mIe[wc] = wrData[7]; mCm[wc] = wrData[6]; mSlow[wc] = wrData[5];
          mExp[wc] = wrData[2];
          if (wrData[1]) begin mRun[wc] = 0; mPend[wc] = 0; end
        end else if (wc == 0) begin
          mBase = int'(wrData) & 'hF8;
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int ez, l;
    ez = 0;
    for (int i = 0; i < 4; i++) if (mZc[i]) ez |= (1 << i);
    l = lowestPend();
    check("zeroCount", int'(zeroCount), ez);
    check("intReq", int'(intReq), (l >= 0) ? 1 : 0);
    check("intVector", int'(intVector), mBase | ((l < 0 ? 0 : l) * 2));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic wr(int ch, int d);
    wrEn = 1'b1; wrChan = ch[1:0]; wrData = d[7:0];
    tick();
    wrEn = 1'b0;
  endtask

  // enDiv 0 = random enable; trigMode 0 off, 1 on, 2 random; ackMode 0 off, 1 always, 2 random
  task automatic runFor(int n, int enDiv, int trigMode, int ackMode);
    for (int k = 0; k < n; k++) begin
      clkEn  = (enDiv == 0) ? 1'($urandom % 2) : (k % enDiv == 0);
      trig   = (trigMode == 0) ? 4'h0 : (trigMode == 1) ? 4'hF : 4'($urandom);
      intAck = (ackMode == 0) ? 1'b0 : (ackMode == 1) ? intReq : (intReq && ($urandom % 4 == 0));
      tick();
    end
    intAck = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    tag = "R1";
    check("reset zeroCount", int'(zeroCount), 0);
    check("reset intReq", int'(intReq), 0);
    check("reset intVector", int'(intVector), 'hD0);

    tag = "R2 R3 R5 R8 fast timer";
    clkEn = 1'b1;
    wr(0, 'h85);
    wr(0, 3);
    runFor(300, 1, 0, 1);

    tag = "R3 R12 slow timer gated enable";
    wr(2, 'hA5);
    wr(2, 2);
    runFor(4000, 3, 0, 1);

    tag = "R4 counter random trigger";
    wr(3, 'hC5);
    wr(3, 5);
    runFor(400, 1, 2, 2);
    tag = "R4 counter wrap at zero constant";
    wr(3, 'hC5);
    wr(3, 0);
    runFor(600, 1, 1, 1);

    tag = "R6 R8 chain without interrupt on ch0";
    wr(2, 'h03);
    wr(3, 'h03);
    wr(0, 'h05);
    wr(0, 2);
    wr(1, 'hC5);
    wr(1, 3);
    runFor(500, 1, 0, 0);

    tag = "R7 stop clears pending";
    wr(0, 'h03);
    wr(1, 'h03);
    runFor(200, 1, 1, 1);

    tag = "R9 R10 priority";
    clkEn = 1'b1;
    wr(0, 'h85);
    wr(0, 1);
    wr(2, 'h85);
    wr(2, 1);
    runFor(40, 1, 0, 0);
    check("both pending vector", int'(intVector), 'hD0);
    intAck = 1'b1;
    tick();
    intAck = 1'b0;
    check("after one ack vector", int'(intVector), 'hD4);
    runFor(300, 1, 0, 2);

    tag = "R11 base write";
    for (int c = 0; c < 4; c++) wr(c, 'h03);
    runFor(5, 1, 0, 1);
    wr(0, 'h60);
    wr(2, 'h20);
    check("base after write", int'(intVector), 'h60);
    check("no request after base write", int'(intReq), 0);
    wr(3, 'hC5);
    wr(3, 1);
    runFor(20, 1, 1, 2);

    tag = "R12 random mix";
    for (int k = 0; k < 4000; k++) begin
      clkEn  = 1'($urandom % 2);
      trig   = 4'($urandom);
      intAck = intReq && ($urandom % 3 == 0);
      if ($urandom % 30 == 0) begin
        wrEn = 1'b1; wrChan = 2'($urandom); wrData = 8'($urandom);
      end else begin
        wrEn = 1'b0;
      end
      tick();
    end
    wrEn = 1'b0;
    intAck = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule